// File: doc/BRIEF.md
# Interrupt and Trap Arbiter

This block decides, once per instruction cycle, whether the processor core must leave its current flow, and where it must go. Maskable sources each present a request flag, an enable bit and a priority level. A short list of hard trap sources sits above all of them in a fixed order. On each cycle strobe the block captures the qualified requests and, on the following clock, picks a winner. The winner is the highest trap if any trap is raised. Otherwise it is the highest-priority interrupt, and that interrupt wins only if its level is above the core's current level.

A winning decision appears as a one-clock take pulse, together with the vector address and the level the core must adopt. The block then holds off until the core acknowledges. A trap stays outstanding from its take until that acknowledge. If a lower-ranked trap is captured during that window, the block raises a reset request and sets a sticky status bit instead of queuing the trap. A higher-ranked trap in the same window waits and is issued after the acknowledge.

Top module: `irq_trap_arb`

## Requirements
- R1: Request flags and trap inputs are captured only on a clock edge where `cyc_stb` is 1; changes between strobes have no effect on `take`.
- R2: An interrupt source takes part in arbitration only when both its flag bit and its enable bit were 1 at the capture edge.
- R3: An interrupt is taken only if the winner's priority is strictly greater than `cur_ipl`; a winner equal to `cur_ipl` produces no take.
- R4: Among captured interrupts, the highest priority wins; on equal priority the lower source number wins.
- R5: `take` is high for exactly one clock, on the clock after the capture edge, with `vec_addr` and `new_ipl` valid in that same clock.
- R6: After a take, no further take is issued until `ack` has been sampled high; a capture made while waiting is evaluated on the clock after the acknowledge edge.
- R7: A captured trap wins over every interrupt regardless of `cur_ipl`; trap 0 ranks highest and rank falls as the index rises; its `new_ipl` is all ones with the top (extension) bit set.
- R8: For an interrupt take, `new_ipl` has its top (extension) bit clear and its lower bits equal to the winner's priority.
- R9: Vector addresses: interrupt n is at 0x14 + 2n (primary) or 0x94 + 2n when `alt_tbl` is 1; trap i is at 0x04 + 2i (primary) or 0x84 + 2i when `alt_tbl` is 1.
- R10: A trap with a higher index than the outstanding trap, captured between that trap's take and its acknowledge, raises `rst_req` for one clock after the capture edge and drops the outstanding state; a lower-index trap in the same window raises no reset.
- R11: `trap_rst_flag` is set together with `rst_req` and stays set until `rst_n` is asserted.
- R12: After reset, `take`, `vec_addr`, `new_ipl`, `rst_req` and `trap_rst_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Instruction cycle start strobe; capture point for requests |
| irq_flag | input | NUM_IRQ | Interrupt request flags |
| irq_en | input | NUM_IRQ | Interrupt enable bits |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed priority levels, source n in bits [n*PRIO_W +: PRIO_W] |
| cur_ipl | input | PRIO_W | Current processor priority level |
| trap_req | input | NUM_TRAP | Hard trap requests, bit 0 ranks highest |
| ack | input | 1 | Core acknowledge of the last take |
| alt_tbl | input | 1 | Selects the alternate vector table |
| take | output | 1 | One-clock pulse: core must vector |
| vec_addr | output | ADDR_W | Vector address to fetch |
| new_ipl | output | PRIO_W+1 | Level to adopt; top bit is the trap extension |
| rst_req | output | 1 | One-clock device reset request on a trap conflict |
| trap_rst_flag | output | 1 | Sticky trap-conflict reset status |

## Verification
The assertions assume `ack` is raised only after a take and before the next one, and that `cur_ipl` and `irq_prio` hold steady from the capture edge through the decision clock. The bench keeps to this by changing inputs only on the falling edge, by raising `ack` once per observed take, and by leaving priorities and level untouched while a strobe is in progress. Trap inputs are dropped again before the next strobe, so that a conflict is provoked only when a scenario asks for one.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
  localparam int unsigned VEC_W          = 24;
  localparam logic [VEC_W-1:0] TRAP_BASE     = 24'h000004;
  localparam logic [VEC_W-1:0] TRAP_BASE_ALT = 24'h000084;
  localparam logic [VEC_W-1:0] IRQ_BASE      = 24'h000014;
  localparam logic [VEC_W-1:0] IRQ_BASE_ALT  = 24'h000094;
endpackage

// File: rtl/prio_arb.sv
module prio_arb #(
  parameter int NUM   = 8,
  parameter int PW    = 3,
  localparam int IW   = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    req,
  input  logic [NUM*PW-1:0] prio,
  output logic              win_v,
  output logic [IW-1:0]     win_idx,
  output logic [PW-1:0]     win_prio
);
  always_comb begin
    win_v    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!win_v || (prio[i*PW +: PW] > win_prio))) begin
        win_v    = 1'b1;
        win_idx  = IW'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end

  // R4: the reported winner is really requesting with its own level
  a_r4_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_v |-> (req[win_idx] && (prio[win_idx*PW +: PW] == win_prio)));
endmodule

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int NUM  = 4,
  localparam int IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0] req,
  output logic           hit,
  output logic [IW-1:0]  idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vec_calc.sv
module vec_calc
  import irq_trap_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic             is_trap,
  input  logic             alt,
  input  logic [IW-1:0]    idx,
  output logic [VEC_W-1:0] addr
);
  logic [VEC_W-1:0] base;
  always_comb begin
    unique case ({is_trap, alt})
      2'b00:   base = IRQ_BASE;
      2'b01:   base = IRQ_BASE_ALT;
      2'b10:   base = TRAP_BASE;
      default: base = TRAP_BASE_ALT;
    endcase
    addr = base + (VEC_W'(idx) << 1);
  end
endmodule

// File: rtl/irq_trap_arb.sv
module irq_trap_arb
  import irq_trap_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_TRAP = 4,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = VEC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_stb,
  input  logic [NUM_IRQ-1:0]      irq_flag,
  input  logic [NUM_IRQ-1:0]      irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cur_ipl,
  input  logic [NUM_TRAP-1:0]     trap_req,
  input  logic                    ack,
  input  logic                    alt_tbl,
  output logic                    take,
  output logic [ADDR_W-1:0]       vec_addr,
  output logic [PRIO_W:0]         new_ipl,
  output logic                    rst_req,
  output logic                    trap_rst_flag
);
  localparam int IIW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int TIW = (NUM_TRAP > 1) ? $clog2(NUM_TRAP) : 1;
  localparam int VIW = (IIW > TIW) ? IIW : TIW;

  // state
  logic [NUM_IRQ-1:0]  samp_irq_q, samp_irq_d;
  logic [NUM_TRAP-1:0] samp_trap_q, samp_trap_d;
  logic                eval_q, eval_d;
  logic                busy_q, busy_d;
  logic                tact_q, tact_d;
  logic [TIW-1:0]      tidx_q, tidx_d;
  logic                take_q, take_d;
  logic [ADDR_W-1:0]   vec_q, vec_d;
  logic [PRIO_W:0]     nipl_q, nipl_d;
  logic                rst_q, rst_d;
  logic                sticky_q, sticky_d;

  // arbitration
  logic               iwin_v;
  logic [IIW-1:0]     iwin_idx;
  logic [PRIO_W-1:0]  iwin_prio;
  logic               twin_v;
  logic [TIW-1:0]     twin_idx;
  logic [NUM_TRAP-1:0] below_mask;
  logic [VIW-1:0]     pick_idx;
  logic [VEC_W-1:0]   pick_vec;

  prio_arb #(.NUM(NUM_IRQ), .PW(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(samp_irq_q), .prio(irq_prio),
    .win_v(iwin_v), .win_idx(iwin_idx), .win_prio(iwin_prio)
  );

  trap_pick #(.NUM(NUM_TRAP)) u_trap (
    .req(samp_trap_q), .hit(twin_v), .idx(twin_idx)
  );

  assign pick_idx = twin_v ? VIW'(twin_idx) : VIW'(iwin_idx);

  vec_calc #(.IW(VIW)) u_vec (
    .is_trap(twin_v), .alt(alt_tbl), .idx(pick_idx), .addr(pick_vec)
  );

  // traps ranked below the outstanding one
  for (genvar g = 0; g < NUM_TRAP; g++) begin : g_below
    assign below_mask[g] = (TIW'(g) > tidx_q);
  end

  always_comb begin
    samp_irq_d  = samp_irq_q;
    samp_trap_d = samp_trap_q;
    eval_d      = eval_q;
    busy_d      = busy_q;
    tact_d      = tact_q;
    tidx_d      = tidx_q;
    take_d      = 1'b0;
    vec_d       = vec_q;
    nipl_d      = nipl_q;
    rst_d       = 1'b0;
    sticky_d    = sticky_q;

    if (busy_q && ack) begin
      busy_d = 1'b0;
      tact_d = 1'b0;
    end

    if (cyc_stb) begin
      samp_irq_d  = irq_flag & irq_en;
      samp_trap_d = trap_req;
      eval_d      = 1'b1;
      if (tact_q && |(trap_req & below_mask)) begin
        rst_d       = 1'b1;
        sticky_d    = 1'b1;
        eval_d      = 1'b0;
        busy_d      = 1'b0;
        tact_d      = 1'b0;
        samp_irq_d  = '0;
        samp_trap_d = '0;
      end
    end else if (eval_q && !busy_q) begin
      eval_d = 1'b0;
      if (twin_v) begin
        take_d = 1'b1;
        busy_d = 1'b1;
        tact_d = 1'b1;
        tidx_d = twin_idx;
        vec_d  = ADDR_W'(pick_vec);
        nipl_d = {1'b1, {PRIO_W{1'b1}}};
      end else if (iwin_v && (iwin_prio > cur_ipl)) begin
        take_d = 1'b1;
        busy_d = 1'b1;
        vec_d  = ADDR_W'(pick_vec);
        nipl_d = {1'b0, iwin_prio};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_irq_q  <= '0;
      samp_trap_q <= '0;
      eval_q      <= 1'b0;
      busy_q      <= 1'b0;
      tact_q      <= 1'b0;
      tidx_q      <= '0;
      take_q      <= 1'b0;
      vec_q       <= '0;
      nipl_q      <= '0;
      rst_q       <= 1'b0;
      sticky_q    <= 1'b0;
    end else begin
      samp_irq_q  <= samp_irq_d;
      samp_trap_q <= samp_trap_d;
      eval_q      <= eval_d;
      busy_q      <= busy_d;
      tact_q      <= tact_d;
      tidx_q      <= tidx_d;
      take_q      <= take_d;
      vec_q       <= vec_d;
      nipl_q      <= nipl_d;
      rst_q       <= rst_d;
      sticky_q    <= sticky_d;
    end
  end

  assign take          = take_q;
  assign vec_addr      = vec_q;
  assign new_ipl       = nipl_q;
  assign rst_req       = rst_q;
  assign trap_rst_flag = sticky_q;

  // R5: take never lasts two clocks
  a_r5_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R6: nothing new while the last take is unacknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack) |=> !take);
  // R3: an interrupt take beats the level seen at decision time
  a_r3_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !new_ipl[PRIO_W]) |-> (new_ipl[PRIO_W-1:0] > $past(cur_ipl)));
  // R7: a trap vector always carries the extension bit
  a_r7_trap_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (vec_addr < ADDR_W'(IRQ_BASE))) |-> new_ipl[PRIO_W]);
  // R11: status stays set once raised
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trap_rst_flag |=> trap_rst_flag);
  // R10: reset request and take never share a clock
  a_r10_rst_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!take && trap_rst_flag));
endmodule

// File: tb/irq_trap_arb_tb_top.sv
`timescale 1ns/1ps
module irq_trap_arb_tb_top;
  localparam int NI = 8;
  localparam int NT = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_stb;
  logic [NI-1:0] irq_flag, irq_en;
  logic [NI*PW-1:0] irq_prio;
  logic [PW-1:0] cur_ipl;
  logic [NT-1:0] trap_req;
  logic ack, alt_tbl;
  logic take, rst_req, trap_rst_flag;
  logic [23:0] vec_addr;
  logic [PW:0] new_ipl;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_trap_arb #(.NUM_IRQ(NI), .NUM_TRAP(NT), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_flag(irq_flag),
    .irq_en(irq_en), .irq_prio(irq_prio), .cur_ipl(cur_ipl),
    .trap_req(trap_req), .ack(ack), .alt_tbl(alt_tbl), .take(take),
    .vec_addr(vec_addr), .new_ipl(new_ipl), .rst_req(rst_req),
    .trap_rst_flag(trap_rst_flag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_prio(int n, int p);
    irq_prio[n*PW +: PW] = PW'(p);
  endtask

  // one strobe clock; returns after the capture edge
  task automatic strobe();
    @(negedge clk) cyc_stb = 1'b1;
    @(negedge clk) cyc_stb = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic clear_in();
    irq_flag = '0; irq_en = '0; trap_req = '0; alt_tbl = 1'b0;
  endtask

  // after strobe(): next falling edge holds the decision
  task automatic expect_take(string tag, logic [23:0] v, logic [PW:0] ipl);
    @(negedge clk);
    check({tag, " take"}, 32'(take), 32'd1);
    check({tag, " vec"}, 32'(vec_addr), 32'(v));
    check({tag, " ipl"}, 32'(new_ipl), 32'(ipl));
    @(negedge clk);
    check({tag, " pulse"}, 32'(take), 32'd0);
  endtask

  task automatic expect_none(string tag);
    @(negedge clk);
    check(tag, 32'(take), 32'd0);
    @(negedge clk);
    check(tag, 32'(take), 32'd0);
  endtask

  task automatic t_reset();
    check("R12 take", 32'(take), 0);
    check("R12 vec", 32'(vec_addr), 0);
    check("R12 ipl", 32'(new_ipl), 0);
    check("R12 rst", 32'(rst_req), 0);
    check("R12 flag", 32'(trap_rst_flag), 0);
  endtask

  task automatic t_single();
    clear_in(); cur_ipl = 3'd2; set_prio(3, 5);
    irq_flag[3] = 1'b1; irq_en[3] = 1'b1;
    strobe();
    expect_take("R5 R8 R9 irq3", 24'h1A, 4'b0101);
    irq_flag = '0; do_ack();
  endtask

  task automatic t_no_strobe();
    clear_in(); irq_flag[1] = 1'b1; irq_en[1] = 1'b1; set_prio(1, 7);
    repeat (4) @(negedge clk);
    check("R1 no capture", 32'(take), 0);
    irq_flag = '0;
    strobe();
    expect_none("R1 dropped flag");
  endtask

  task automatic t_enable();
    clear_in(); irq_flag[4] = 1'b1; set_prio(4, 7);
    strobe();
    expect_none("R2 disabled");
  endtask

  task automatic t_level();
    clear_in(); cur_ipl = 3'd4; set_prio(0, 4);
    irq_flag[0] = 1'b1; irq_en[0] = 1'b1;
    strobe();
    expect_none("R3 equal level");
    set_prio(0, 5);
    strobe();
    expect_take("R3 above level", 24'h14, 4'b0101);
    do_ack();
  endtask

  task automatic t_order();
    clear_in(); cur_ipl = 3'd0;
    set_prio(6, 4); set_prio(2, 4); set_prio(5, 6);
    irq_flag = 8'b0110_0100; irq_en = 8'hFF;
    strobe();
    expect_take("R4 highest", 24'h1E, 4'b0110);
    do_ack();
    irq_flag = 8'b0100_0100;
    strobe();
    expect_take("R4 tie", 24'h18, 4'b0100);
    do_ack();
    alt_tbl = 1'b1;
    strobe();
    expect_take("R9 alt irq", 24'h98, 4'b0100);
    do_ack();
  endtask

  task automatic t_hold();
    clear_in(); cur_ipl = 3'd0; set_prio(1, 2); set_prio(7, 3);
    irq_flag[1] = 1'b1; irq_en = 8'hFF;
    strobe();
    expect_take("R6 first", 24'h16, 4'b0010);
    irq_flag = 8'h80;
    strobe();
    expect_none("R6 held");
    do_ack();
    @(negedge clk);
    check("R6 after ack take", 32'(take), 1);
    check("R6 after ack vec", 32'(vec_addr), 32'h22);
    do_ack();
  endtask

  task automatic t_trap();
    clear_in(); cur_ipl = 3'd7; set_prio(2, 7);
    irq_flag[2] = 1'b1; irq_en[2] = 1'b1; trap_req[1] = 1'b1;
    strobe();
    trap_req = '0; irq_flag = '0;
    expect_take("R7 trap1", 24'h06, 4'b1111);
    do_ack();
    alt_tbl = 1'b1; trap_req[0] = 1'b1;
    strobe();
    trap_req = '0;
    expect_take("R9 alt trap", 24'h84, 4'b1111);
    do_ack();
  endtask

  task automatic t_conflict();
    clear_in(); trap_req[1] = 1'b1;
    strobe(); trap_req = '0;
    expect_take("R10 outer", 24'h06, 4'b1111);
    trap_req[0] = 1'b1;
    strobe(); trap_req = '0;
    check("R10 higher no rst", 32'(rst_req), 0);
    do_ack();
    @(negedge clk);
    check("R10 nested take", 32'(take), 1);
    check("R10 nested vec", 32'(vec_addr), 32'h04);
    do_ack();
    trap_req[1] = 1'b1;
    strobe(); trap_req = '0;
    expect_take("R10 again", 24'h06, 4'b1111);
    trap_req[2] = 1'b1;
    strobe(); trap_req = '0;
    check("R10 rst", 32'(rst_req), 1);
    check("R11 flag", 32'(trap_rst_flag), 1);
    @(negedge clk);
    check("R10 rst pulse", 32'(rst_req), 0);
    check("R10 no take", 32'(take), 0);
    repeat (5) @(negedge clk);
    check("R11 sticky", 32'(trap_rst_flag), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_stb = 1'b0; ack = 1'b0; cur_ipl = '0; irq_prio = '0;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_no_strobe();
    t_enable();
    t_level();
    t_order();
    t_hold();
    t_trap();
    t_conflict();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule